// File: doc/BRIEF.md
# ECC Memory Controller Error Reporting Unit

This unit sits beside the data path of an ECC-protected DRAM controller and turns per-transaction error indications into counted, logged and interrupt-gated events. Every request presents its address together with two flags from the ECC logic: one for a single-bit error that has already been corrected, and one for an uncorrectable multi-bit error. The unit compares the address in parallel against a set of programmed chip-select windows. When no enabled window claims the address, the unit reports a memory-select error.

Corrected single-bit errors advance a saturating counter. A threshold status bit is raised when an increment lands exactly on a programmable threshold. Multi-bit read errors and memory-select errors each raise their own status bit. The critical interrupt is the OR of every pending status bit whose enable is set. A sticky log keeps the type and address of the first error until it is cleared, and marks any further errors with a flag.

For a request that misses every window, the unit names the lowest enabled chip select for a substitute dummy access. It then tells the command sequencer to keep the pins quiet once the first read strobes have returned. The ECC encode and decode logic and the DRAM command sequencing belong to other blocks.

Top module: `mc_err_report`

## Requirements
- R1: Each cycle with `txn_valid` and `sbe_hit` high increments `sbe_count` on the next edge. The count saturates at 2^CW-1. `sbe_cnt_clr` forces it to zero and wins over an increment in the same cycle.
- R2: `err_sts[0]` (threshold) is set when an increment moves `sbe_count` onto a non-zero `sbe_thresh`. A threshold of zero never sets it, and a saturated counter that does not move never sets it.
- R3: `err_sts[1]` (multi-bit) is set by `txn_valid & mbe_hit & txn_is_read`. A multi-bit flag on a write is ignored.
- R4: `cs_hit`/`cs_sel` combinationally report whether `txn_addr` lies in any enabled window, with both the start and the end address included. When windows overlap, the lowest index wins.
- R5: `err_sts[2]` (memory select) is set by a valid request with no window hit.
- R6: `crit_irq` is the OR of `err_sts & irq_en`. Status bits clear by writing a one to `sts_clr`, and a new event in the same cycle wins over the clear. The enables never change the status.
- R7: The first error captures `log_code` (1 = single-bit, 2 = multi-bit, 3 = memory select; when several occur in one cycle, memory select beats multi-bit, which beats single-bit) and `log_addr`. The log then holds. Any later error, or more than one kind at capture, sets `log_multi`. `log_clr` empties the log, and an error in the same cycle is captured afresh.
- R8: One cycle after a memory-select error with `sample_pts_en` low and at least one window enabled, `dummy_vld` pulses and `dummy_cs` names the lowest enabled window. No pulse occurs otherwise.
- R9: After a memory-select request, `rd_strobe_ret` sets `pin_block` on the next edge. It stays set until the next valid request, which re-arms (on a miss) or clears the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_valid | input | 1 | Request presented this cycle |
| txn_addr | input | AW | Request address |
| txn_is_read | input | 1 | Request is a read |
| sbe_hit | input | 1 | Corrected single-bit error on this request |
| mbe_hit | input | 1 | Uncorrectable multi-bit error on this request |
| cs_lo | input | NCS*AW | Window start addresses, window i in bits [i*AW +: AW] |
| cs_hi | input | NCS*AW | Window end addresses (inclusive) |
| cs_en | input | NCS | Window enables |
| sample_pts_en | input | 1 | Sample points in use (suppresses dummy access) |
| rd_strobe_ret | input | 1 | First read data strobes returned |
| sbe_thresh | input | CW | Single-bit threshold, 0 = off |
| sbe_cnt_clr | input | 1 | Clear single-bit counter |
| irq_en | input | 3 | Per-status interrupt enables |
| sts_clr | input | 3 | Write-one-to-clear for status |
| log_clr | input | 1 | Empty the error log |
| cs_hit | output | 1 | Address falls in an enabled window |
| cs_sel | output | CSW | Lowest matching window index |
| sbe_count | output | CW | Single-bit error count |
| err_sts | output | 3 | Status: [0] threshold, [1] multi-bit, [2] memory select |
| crit_irq | output | 1 | Critical interrupt |
| log_valid | output | 1 | Log holds an error |
| log_code | output | 2 | Logged error type |
| log_addr | output | AW | Logged address |
| log_multi | output | 1 | Further errors since capture |
| dummy_vld | output | 1 | Issue substitute dummy access |
| dummy_cs | output | CSW | Chip select for the dummy access |
| pin_block | output | 1 | Keep transactions off the memory pins |

## Verification
The window match is combinational, so `cs_hit` and `cs_sel` are checked in the same cycle, shortly after the request inputs settle. Every other result is registered exactly once: the counter, status, log, dummy pulse and pin blocking all change on the edge that samples the event and are compared at the following falling edge. `crit_irq` is combinational from the registered status and the live enables, so it is checked against the enables present at that falling edge. A behavioural model advances on each rising edge from the inputs driven at the previous falling edge and is compared on every cycle.

// File: rtl/mcer_pkg.sv
package mcer_pkg;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_SBE  = 2'd1,
        ERR_MBE  = 2'd2,
        ERR_MSE  = 2'd3
    } err_code_e;

    typedef enum logic [1:0] {
        PB_IDLE  = 2'd0,
        PB_ARMED = 2'd1,
        PB_BLOCK = 2'd2
    } pb_state_e;

    localparam int STS_THR = 0;
    localparam int STS_MBE = 1;
    localparam int STS_MSE = 2;
    localparam int STS_W   = 3;

endpackage

// File: rtl/mcer_cs_match.sv
module mcer_cs_match #(
    parameter int AW  = 32,
    parameter int NCS = 4,
    parameter int CSW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [NCS*AW-1:0] lo,
    input  logic [NCS*AW-1:0] hi,
    input  logic [NCS-1:0]    en,
    output logic              hit,
    output logic [CSW-1:0]    sel,
    output logic              first_vld,
    output logic [CSW-1:0]    first_idx
);

    logic [NCS-1:0] in_win;

    for (genvar g = 0; g < NCS; g++) begin : g_win
        assign in_win[g] = en[g] && (addr >= lo[g*AW +: AW]) && (addr <= hi[g*AW +: AW]);
    end

    always_comb begin
        hit       = 1'b0;
        sel       = '0;
        first_vld = 1'b0;
        first_idx = '0;
        for (int i = NCS - 1; i >= 0; i--) begin
            if (in_win[i]) begin
                hit = 1'b1;
                sel = CSW'(i);
            end
            if (en[i]) begin
                first_vld = 1'b1;
                first_idx = CSW'(i);
            end
        end
    end

    // R4: a reported hit always names an enabled window
    assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> en[sel]);

    // R4: no enabled window below the selected one may also contain the address
    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((in_win & ((NCS'(1) << sel) - NCS'(1))) == '0));

endmodule

// File: rtl/mcer_sbe_ctr.sv
module mcer_sbe_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    input  logic [CW-1:0] thresh,
    output logic [CW-1:0] cnt,
    output logic          thr_hit
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t s_d, s_q;
    logic can_inc;

    always_comb begin
        s_d     = s_q;
        can_inc = inc && !clr && (s_q.cnt != CNT_MAX);
        if (clr) begin
            s_d.cnt = '0;
        end else if (can_inc) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        thr_hit = can_inc && (thresh != '0) && (s_d.cnt == thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;

    // R1: a full counter stays full unless cleared
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !clr) |=> (s_q.cnt == CNT_MAX));

    // R1: without a clear the count never goes down
    assert_monotonic_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (s_q.cnt >= $past(s_q.cnt)));

    // R1: a clear always lands on zero
    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0));

endmodule

// File: rtl/mcer_err_log.sv
module mcer_err_log
    import mcer_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_sbe,
    input  logic          ev_mbe,
    input  logic          ev_mse,
    input  logic [AW-1:0] addr,
    input  logic          clr,
    output logic          valid,
    output err_code_e     code,
    output logic [AW-1:0] log_addr,
    output logic          multi
);

    typedef struct packed {
        logic          valid;
        err_code_e     code;
        logic [AW-1:0] addr;
        logic          multi;
    } log_t;

    log_t s_d, s_q;
    logic      any_ev;
    logic      many_ev;
    err_code_e new_code;

    always_comb begin
        any_ev  = ev_sbe | ev_mbe | ev_mse;
        many_ev = (32'(ev_sbe) + 32'(ev_mbe) + 32'(ev_mse)) > 32'd1;
        if (ev_mse)      new_code = ERR_MSE;
        else if (ev_mbe) new_code = ERR_MBE;
        else if (ev_sbe) new_code = ERR_SBE;
        else             new_code = ERR_NONE;

        s_d = s_q;
        if (clr) begin
            s_d.valid = 1'b0;
            s_d.multi = 1'b0;
        end
        if (any_ev) begin
            if (s_d.valid) begin
                s_d.multi = 1'b1;
            end else begin
                s_d.valid = 1'b1;
                s_d.code  = new_code;
                s_d.addr  = addr;
                s_d.multi = many_ev;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{valid: 1'b0, code: ERR_NONE, addr: '0, multi: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign valid    = s_q.valid;
    assign code     = s_q.code;
    assign log_addr = s_q.addr;
    assign multi    = s_q.multi;

    // R7: a filled log keeps its contents until cleared
    assert_log_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && !clr) |=> ($stable(s_q.addr) && $stable(s_q.code) && s_q.valid));

    // R7: the multiple-error flag only exists alongside a filled log
    assert_multi_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.multi |-> s_q.valid);

endmodule

// File: rtl/mc_err_report.sv
module mc_err_report
    import mcer_pkg::*;
#(
    parameter int AW  = 32,
    parameter int NCS = 4,
    parameter int CW  = 16,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_valid,
    input  logic [AW-1:0]     txn_addr,
    input  logic              txn_is_read,
    input  logic              sbe_hit,
    input  logic              mbe_hit,
    input  logic [NCS*AW-1:0] cs_lo,
    input  logic [NCS*AW-1:0] cs_hi,
    input  logic [NCS-1:0]    cs_en,
    input  logic              sample_pts_en,
    input  logic              rd_strobe_ret,
    input  logic [CW-1:0]     sbe_thresh,
    input  logic              sbe_cnt_clr,
    input  logic [2:0]        irq_en,
    input  logic [2:0]        sts_clr,
    input  logic              log_clr,
    output logic              cs_hit,
    output logic [CSW-1:0]    cs_sel,
    output logic [CW-1:0]     sbe_count,
    output logic [2:0]        err_sts,
    output logic              crit_irq,
    output logic              log_valid,
    output logic [1:0]        log_code,
    output logic [AW-1:0]     log_addr,
    output logic              log_multi,
    output logic              dummy_vld,
    output logic [CSW-1:0]    dummy_cs,
    output logic              pin_block
);

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic             dv;
        logic [CSW-1:0]   dcs;
        pb_state_e        pb;
    } top_t;

    top_t s_d, s_q;

    logic           first_vld;
    logic [CSW-1:0] first_idx;
    logic           thr_hit;
    logic           ev_sbe, ev_mbe, ev_mse;
    err_code_e      code_w;

    mcer_cs_match #(.AW(AW), .NCS(NCS), .CSW(CSW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (txn_addr),
        .lo        (cs_lo),
        .hi        (cs_hi),
        .en        (cs_en),
        .hit       (cs_hit),
        .sel       (cs_sel),
        .first_vld (first_vld),
        .first_idx (first_idx)
    );

    assign ev_sbe = txn_valid && sbe_hit;
    assign ev_mbe = txn_valid && mbe_hit && txn_is_read;
    assign ev_mse = txn_valid && !cs_hit;

    mcer_sbe_ctr #(.CW(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (ev_sbe),
        .clr     (sbe_cnt_clr),
        .thresh  (sbe_thresh),
        .cnt     (sbe_count),
        .thr_hit (thr_hit)
    );

    mcer_err_log #(.AW(AW)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_sbe   (ev_sbe),
        .ev_mbe   (ev_mbe),
        .ev_mse   (ev_mse),
        .addr     (txn_addr),
        .clr      (log_clr),
        .valid    (log_valid),
        .code     (code_w),
        .log_addr (log_addr),
        .multi    (log_multi)
    );

    assign log_code = code_w;

    always_comb begin
        logic [STS_W-1:0] set_v;
        s_d = s_q;

        set_v          = '0;
        set_v[STS_THR] = thr_hit;
        set_v[STS_MBE] = ev_mbe;
        set_v[STS_MSE] = ev_mse;
        s_d.sts = (s_q.sts & ~sts_clr) | set_v;

        s_d.dv = ev_mse && !sample_pts_en && first_vld;
        if (s_d.dv) begin
            s_d.dcs = first_idx;
        end

        if (txn_valid) begin
            s_d.pb = ev_mse ? PB_ARMED : PB_IDLE;
        end else if (s_q.pb == PB_ARMED && rd_strobe_ret) begin
            s_d.pb = PB_BLOCK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sts: '0, dv: 1'b0, dcs: '0, pb: PB_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign err_sts   = s_q.sts;
    assign crit_irq  = |(s_q.sts & irq_en);
    assign dummy_vld = s_q.dv;
    assign dummy_cs  = s_q.dcs;
    assign pin_block = (s_q.pb == PB_BLOCK);

    // R3: the multi-bit status only rises after a multi-bit read error
    assert_mbe_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sts[STS_MBE]) |-> $past(txn_valid && mbe_hit && txn_is_read));

    // R5: the memory-select status only rises after a missed request
    assert_mse_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sts[STS_MSE]) |-> $past(txn_valid && !cs_hit));

    // R2: the threshold status only rises from a counter increment
    assert_thr_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sts[STS_THR]) |-> ($past(txn_valid && sbe_hit) && (sbe_count == $past(sbe_thresh))));

    // R8: a dummy pulse needs a miss without sample points one cycle earlier
    assert_dummy_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dummy_vld |-> $past(txn_valid && !cs_hit && !sample_pts_en && (cs_en != '0)));

    // R9: pin blocking begins only on returned strobes
    assert_block_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_block) |-> $past(rd_strobe_ret && !txn_valid));

    // R9: a new request always ends blocking
    assert_block_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> !pin_block);

endmodule

// File: tb/tb_mc_err_report.sv
module tb_mc_err_report;

    localparam int AW  = 16;
    localparam int NCS = 4;
    localparam int CW  = 4;
    localparam int CSW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              txn_valid = 1'b0;
    logic [AW-1:0]     txn_addr = '0;
    logic              txn_is_read = 1'b0;
    logic              sbe_hit = 1'b0;
    logic              mbe_hit = 1'b0;
    logic [NCS*AW-1:0] cs_lo = '0;
    logic [NCS*AW-1:0] cs_hi = '0;
    logic [NCS-1:0]    cs_en = '0;
    logic              sample_pts_en = 1'b0;
    logic              rd_strobe_ret = 1'b0;
    logic [CW-1:0]     sbe_thresh = '0;
    logic              sbe_cnt_clr = 1'b0;
    logic [2:0]        irq_en = '0;
    logic [2:0]        sts_clr = '0;
    logic              log_clr = 1'b0;
    logic              cs_hit;
    logic [CSW-1:0]    cs_sel;
    logic [CW-1:0]     sbe_count;
    logic [2:0]        err_sts;
    logic              crit_irq;
    logic              log_valid;
    logic [1:0]        log_code;
    logic [AW-1:0]     log_addr;
    logic              log_multi;
    logic              dummy_vld;
    logic [CSW-1:0]    dummy_cs;
    logic              pin_block;

    mc_err_report #(.AW(AW), .NCS(NCS), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_addr(txn_addr),
        .txn_is_read(txn_is_read), .sbe_hit(sbe_hit), .mbe_hit(mbe_hit),
        .cs_lo(cs_lo), .cs_hi(cs_hi), .cs_en(cs_en), .sample_pts_en(sample_pts_en),
        .rd_strobe_ret(rd_strobe_ret), .sbe_thresh(sbe_thresh), .sbe_cnt_clr(sbe_cnt_clr),
        .irq_en(irq_en), .sts_clr(sts_clr), .log_clr(log_clr), .cs_hit(cs_hit),
        .cs_sel(cs_sel), .sbe_count(sbe_count), .err_sts(err_sts), .crit_irq(crit_irq),
        .log_valid(log_valid), .log_code(log_code), .log_addr(log_addr),
        .log_multi(log_multi), .dummy_vld(dummy_vld), .dummy_cs(dummy_cs),
        .pin_block(pin_block)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_cnt = 0;
    int m_sts[3] = '{0, 0, 0};
    int m_lv = 0, m_lc = 0, m_la = 0, m_lm = 0;
    int m_dv = 0, m_dcs = 0;
    int m_pb = 0; // 0 idle, 1 armed, 2 blocked
    int lo_a[NCS];
    int hi_a[NCS];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_win(input int i, input int lo, input int hi);
        lo_a[i] = lo;
        hi_a[i] = hi;
        cs_lo[i*AW +: AW] = AW'(lo);
        cs_hi[i*AW +: AW] = AW'(hi);
    endtask

    function automatic int model_sel(input int a, output int hit);
        hit = 0;
        for (int i = 0; i < NCS; i++) begin
            if (cs_en[i] && a >= lo_a[i] && a <= hi_a[i]) begin
                hit = 1;
                return i;
            end
        end
        return 0;
    endfunction

    function automatic int model_first(output int vld);
        vld = 0;
        for (int i = 0; i < NCS; i++) begin
            if (cs_en[i]) begin
                vld = 1;
                return i;
            end
        end
        return 0;
    endfunction

    task automatic compare_all();
        chk("R1 sbe_count", int'(sbe_count), m_cnt);
        chk("R2 sts_thr", int'(err_sts[0]), m_sts[0]);
        chk("R3 sts_mbe", int'(err_sts[1]), m_sts[1]);
        chk("R5 sts_mse", int'(err_sts[2]), m_sts[2]);
        chk("R6 crit_irq", int'(crit_irq),
            int'((m_sts[0] != 0 && irq_en[0]) || (m_sts[1] != 0 && irq_en[1]) || (m_sts[2] != 0 && irq_en[2])));
        chk("R7 log_valid", int'(log_valid), m_lv);
        if (m_lv != 0) begin
            chk("R7 log_code", int'(log_code), m_lc);
            chk("R7 log_addr", int'(log_addr), m_la);
        end
        chk("R7 log_multi", int'(log_multi), m_lm);
        chk("R8 dummy_vld", int'(dummy_vld), m_dv);
        if (m_dv != 0) chk("R8 dummy_cs", int'(dummy_cs), m_dcs);
        chk("R9 pin_block", int'(pin_block), int'(m_pb == 2));
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic step(input bit v, input int a, input bit rd, input bit sb, input bit mb, input bit strb);
        int hit, sel, fv, fi, sbe_e, mbe_e, mse_e, thr, nev, base_v;
        txn_valid = v; txn_addr = AW'(a); txn_is_read = rd;
        sbe_hit = sb; mbe_hit = mb; rd_strobe_ret = strb;
        #1;
        sel = model_sel(a, hit);
        chk("R4 cs_hit", int'(cs_hit), hit);
        if (hit != 0) chk("R4 cs_sel", int'(cs_sel), sel);
        @(posedge clk);
        fi = model_first(fv);
        sbe_e = int'(v && sb);
        mbe_e = int'(v && mb && rd);
        mse_e = int'(v && hit == 0);
        thr = int'(sbe_e != 0 && !sbe_cnt_clr && m_cnt != 15 &&
                   (m_cnt + 1) == int'(sbe_thresh) && sbe_thresh != 0);
        if (sbe_cnt_clr) m_cnt = 0;
        else if (sbe_e != 0 && m_cnt != 15) m_cnt++;
        for (int k = 0; k < 3; k++) if (sts_clr[k]) m_sts[k] = 0;
        if (thr != 0) m_sts[0] = 1;
        if (mbe_e != 0) m_sts[1] = 1;
        if (mse_e != 0) m_sts[2] = 1;
        base_v = m_lv;
        if (log_clr) begin base_v = 0; m_lv = 0; m_lm = 0; end
        nev = sbe_e + mbe_e + mse_e;
        if (nev > 0) begin
            if (base_v != 0) m_lm = 1;
            else begin
                m_lv = 1;
                m_lc = (mse_e != 0) ? 3 : (mbe_e != 0) ? 2 : 1;
                m_la = a;
                m_lm = int'(nev > 1);
            end
        end
        m_dv = int'(mse_e != 0 && !sample_pts_en && fv != 0);
        if (m_dv != 0) m_dcs = fi;
        if (v) m_pb = (mse_e != 0) ? 1 : 0;
        else if (m_pb == 1 && strb) m_pb = 2;
        @(negedge clk);
        compare_all();
        sbe_cnt_clr = 1'b0; sts_clr = '0; log_clr = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_win(0, 16'h1000, 16'h1FFF);
        set_win(1, 16'h1800, 16'h2FFF);
        set_win(2, 16'h8000, 16'h8FFF);
        set_win(3, 16'h9000, 16'h9FFF);
        cs_en = 4'b1011;
        sbe_thresh = 4'd3;
        irq_en = 3'b111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state: R1 counter, R7 log, R9 blocking all idle
        compare_all();
        chk("R1 reset count", int'(sbe_count), 0);

        // R4 window boundaries and overlap, all hits (no error)
        step(1, 16'h1000, 1, 0, 0, 0);
        step(1, 16'h1FFF, 1, 0, 0, 0);
        step(1, 16'h1800, 1, 0, 0, 0);
        step(1, 16'h2000, 0, 0, 0, 0);
        step(1, 16'h2FFF, 1, 0, 0, 0);
        step(1, 16'h9000, 1, 0, 0, 0);
        chk("R4 no error on hits", int'(log_valid), 0);

        // R2 threshold: three corrected errors reach 3
        step(1, 16'h1100, 1, 1, 0, 0);
        step(1, 16'h1104, 1, 1, 0, 0);
        chk("R2 below threshold", int'(err_sts[0]), 0);
        step(1, 16'h1108, 1, 1, 0, 0);
        chk("R2 threshold hit", int'(err_sts[0]), 1);
        chk("R7 first sbe logged", int'(log_addr), 16'h1100);

        // R1 saturation
        for (int i = 0; i < 14; i++) step(1, 16'h1200, 1, 1, 0, 0);
        chk("R1 saturated", int'(sbe_count), 15);
        // R2 saturated counter at threshold 15 does not raise again
        sts_clr = 3'b001; sbe_thresh = 4'd15;
        step(1, 16'h1200, 1, 1, 0, 0);
        chk("R2 no refire at saturation", int'(err_sts[0]), 0);
        // R1 clear wins over increment
        sbe_cnt_clr = 1'b1;
        step(1, 16'h1200, 1, 1, 0, 0);
        chk("R1 clear priority", int'(sbe_count), 0);
        // R2 threshold zero disables
        sbe_thresh = 4'd0;
        step(1, 16'h1200, 1, 1, 0, 0);
        chk("R2 zero threshold", int'(err_sts[0]), 0);

        // R3 multi-bit on write ignored, on read sets
        sts_clr = 3'b111;
        step(1, 16'h1300, 0, 0, 1, 0);
        chk("R3 write ignored", int'(err_sts[1]), 0);
        step(1, 16'h1304, 1, 0, 1, 0);
        chk("R3 read sets", int'(err_sts[1]), 1);

        // R6 enable gating and W1C with set priority
        irq_en = 3'b000;
        idle();
        chk("R6 gated off", int'(crit_irq), 0);
        irq_en = 3'b010;
        idle();
        chk("R6 enabled", int'(crit_irq), 1);
        sts_clr = 3'b010;
        step(1, 16'h1308, 1, 0, 1, 0);
        chk("R6 set beats clear", int'(err_sts[1]), 1);
        sts_clr = 3'b010;
        idle();
        chk("R6 cleared", int'(err_sts[1]), 0);

        // R5/R7 log clear with simultaneous sbe and miss
        log_clr = 1'b1;
        step(1, 16'h3000, 1, 1, 0, 0);
        chk("R7 code mse priority", int'(log_code), 3);
        chk("R7 multi at capture", int'(log_multi), 1);
        chk("R5 miss past end", int'(err_sts[2]), 1);
        log_clr = 1'b1;
        step(1, 16'h0FFF, 1, 0, 0, 0);
        chk("R7 recapture", int'(log_addr), 16'h0FFF);
        chk("R7 single capture", int'(log_multi), 0);
        step(1, 16'h8500, 1, 0, 0, 0);
        chk("R7 later error flagged", int'(log_multi), 1);
        chk("R7 address held", int'(log_addr), 16'h0FFF);

        // R8 dummy access selection
        cs_en = 4'b1110;
        step(1, 16'h5000, 1, 0, 0, 0);
        chk("R8 lowest enabled", int'(dummy_cs), 1);
        sample_pts_en = 1'b1;
        step(1, 16'h5000, 1, 0, 0, 0);
        chk("R8 sample points suppress", int'(dummy_vld), 0);
        sample_pts_en = 1'b0;
        cs_en = 4'b0000;
        step(1, 16'h5000, 1, 0, 0, 0);
        chk("R8 no window enabled", int'(dummy_vld), 0);
        cs_en = 4'b1011;

        // R9 pin blocking
        step(1, 16'h6000, 1, 0, 0, 0);
        idle();
        chk("R9 armed not blocked", int'(pin_block), 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R9 blocked after strobe", int'(pin_block), 1);
        idle();
        chk("R9 holds", int'(pin_block), 1);
        step(1, 16'h1000, 1, 0, 0, 0);
        chk("R9 released", int'(pin_block), 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R9 strobe without miss", int'(pin_block), 0);
        idle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule